// File: doc/BRIEF.md
# Exception Acceptance and Return Controller

This block decides, cycle by cycle, what a processor does with an incoming synchronous exception, ordinary interrupt or non-maskable interrupt (NMI). The decision depends on a block bit held in the current status register (SR). When the bit is clear, a request is taken. The current program counter (PC) and SR are captured into a saved-PC and saved-SR pair. The PC is steered to a handler vector, and the SR is returned with the block bit set.

When the block bit is set, the kind of request decides what happens:
- A synchronous exception other than a user break forces a restart in the manner of a manual reset, at a fixed reset address.
- A user break is instead signalled on its own output.
- Ordinary interrupts are parked until software clears the bit.
- An NMI is either parked or taken, according to a software-set policy input.

A return-from-exception strobe reloads PC and SR from the saved pair.

Redirect, SR update and the reset request are combinational in the request cycle. The saved pair and the parked-interrupt flags are registers that update at the following clock edge.

Top module: `exc_accept_ctrl`

## Requirements
- R1: With SR bit 28 (block bit) at 0, a valid exception whose type code is not 6'h3F is accepted in the same cycle: `redir_o`=1, `redir_pc_o`=`vec_i`, `sr_wr_o`=1, `sr_new_o`=`cur_sr_i` with bit 28 set, and `acc_kind_o`=1. The kind codes are 0 none, 1 exception, 2 NMI and 3 interrupt.
- R2: On any acceptance, `spc_o` and `ssr_o` show the PC and SR of the accepting cycle from the next cycle on. They are unchanged when nothing is accepted.
- R3: With the block bit at 1, an exception whose type is not 6'h3F pulses `mrst_o` for that cycle. It redirects to 32'hA000_0000 and gives `sr_new_o`=32'h7000_00F0.
- R4: The cycle after `mrst_o`, `spc_o` and `ssr_o` read 0. All parked interrupts are discarded, including requests raised in the same cycle as the reset request.
- R5: With the block bit at 1, an exception of type 6'h3F (user break) pulses `ubrk_o`. It causes no redirect and no `mrst_o`, and leaves `spc_o`/`ssr_o` unchanged.
- R6: An ordinary interrupt raised while blocked is parked. It is accepted (kind 3) in the first cycle the block bit reads 0.
- R7: An NMI raised while blocked is accepted at once (kind 2) when `nmi_blk_take_i`=1. It is parked when that input is 0, and a parked NMI is taken as soon as the bit clears or the policy input becomes 1.
- R8: A `rte_i` strobe redirects to `spc_o` and drives `sr_new_o`=`ssr_o` with `sr_wr_o`=1. It uses `acc_kind_o`=0.
- R9: Precedence in one cycle is exception, then return, then NMI, then ordinary interrupt. A losing NMI or interrupt stays parked.
- R10: A parked request is cleared in the cycle it is accepted and is taken only once.
- R11: After reset all strobes and redirect outputs are 0 and `spc_o`, `ssr_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Synchronous exception strobe |
| exc_type_i | input | 6 | Exception type code (6'h3F = user break) |
| irq_req_i | input | 1 | Ordinary interrupt request strobe |
| nmi_req_i | input | 1 | NMI request strobe |
| nmi_blk_take_i | input | 1 | 1: take NMI even while blocked |
| rte_i | input | 1 | Return-from-exception strobe |
| cur_pc_i | input | 32 | Current PC |
| cur_sr_i | input | 32 | Current SR |
| vec_i | input | 32 | Handler vector |
| redir_o | output | 1 | PC redirect valid |
| redir_pc_o | output | 32 | Redirect target |
| sr_wr_o | output | 1 | SR update valid |
| sr_new_o | output | 32 | New SR value |
| acc_kind_o | output | 2 | Kind of accepted request |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved SR |
| mrst_o | output | 1 | Manual-reset request pulse |
| ubrk_o | output | 1 | User break while blocked |

## Verification
The main decision is driven with each request kind alone, both blocked and unblocked, and then with colliding requests in one cycle. Single requests separate plain acceptance from the reset path and the user-break path. Collisions expose a wrong precedence or a parked request that gets lost. Blocked NMIs are tried under both policy settings and then released by a policy change or by clearing the bit, which tells apart a dropped NMI, an NMI taken twice and an NMI that ignores the policy. Return strobes following acceptances, and a reset path taken with an interrupt parked, show whether the saved pair and the parked flags hold or clear at the right edge.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_EXC  = 2'd1,
    KIND_NMI  = 2'd2,
    KIND_IRQ  = 2'd3
  } acc_kind_e;

  localparam int unsigned SRC_NMI = 0;
  localparam int unsigned SRC_IRQ = 1;
  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/exc_pend_flag.sv
module exc_pend_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic req_i,
  input  logic take_i,
  input  logic flush_i,
  output logic eff_o
);
  logic pend_q, pend_d;

  assign eff_o = pend_q | req_i;

  always_comb begin
    pend_d = pend_q;
    if (flush_i)     pend_d = 1'b0;
    else if (take_i) pend_d = 1'b0;
    else if (req_i)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  // R10: a taken request leaves nothing parked
  p_take_clears_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    take_i |=> !pend_q);
  // R4: flush discards even a same-cycle request
  p_flush_clears_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> !pend_q);
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_ctrl_pkg::*;
#(
  parameter int unsigned        XLEN      = 32,
  parameter int unsigned        TYPE_W    = 6,
  parameter int unsigned        BL_BIT    = 28,
  parameter logic [TYPE_W-1:0]  UBRK_CODE = '1,
  parameter logic [XLEN-1:0]    RST_PC    = 32'hA000_0000,
  parameter logic [XLEN-1:0]    RST_SR    = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              nmi_eff_i,
  input  logic              irq_eff_i,
  input  logic              nmi_blk_take_i,
  input  logic              rte_i,
  input  logic [XLEN-1:0]   cur_sr_i,
  input  logic [XLEN-1:0]   vec_i,
  input  logic [XLEN-1:0]   spc_i,
  input  logic [XLEN-1:0]   ssr_i,
  output logic              acc_o,
  output acc_kind_e         kind_o,
  output logic              mrst_o,
  output logic              ubrk_o,
  output logic              take_nmi_o,
  output logic              take_irq_o,
  output logic              redir_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic              sr_wr_o,
  output logic [XLEN-1:0]   sr_new_o
);
  localparam logic [XLEN-1:0] BL_MASK = XLEN'(1) << BL_BIT;

  logic blocked, is_ubrk, rte_take;
  assign blocked = cur_sr_i[BL_BIT];
  assign is_ubrk = (exc_type_i == UBRK_CODE);

  always_comb begin
    acc_o      = 1'b0;
    kind_o     = KIND_NONE;
    mrst_o     = 1'b0;
    ubrk_o     = 1'b0;
    rte_take   = 1'b0;
    take_nmi_o = 1'b0;
    take_irq_o = 1'b0;
    redir_o    = 1'b0;
    redir_pc_o = '0;
    sr_wr_o    = 1'b0;
    sr_new_o   = '0;
    if (exc_req_i) begin
      if (!blocked) begin
        acc_o  = 1'b1;
        kind_o = KIND_EXC;
      end else if (is_ubrk) begin
        ubrk_o = 1'b1;
      end else begin
        mrst_o     = 1'b1;
        redir_o    = 1'b1;
        redir_pc_o = RST_PC;
        sr_wr_o    = 1'b1;
        sr_new_o   = RST_SR;
      end
    end else if (rte_i) begin
      rte_take   = 1'b1;
      redir_o    = 1'b1;
      redir_pc_o = spc_i;
      sr_wr_o    = 1'b1;
      sr_new_o   = ssr_i;
    end else if (nmi_eff_i && (!blocked || nmi_blk_take_i)) begin
      acc_o      = 1'b1;
      kind_o     = KIND_NMI;
      take_nmi_o = 1'b1;
    end else if (irq_eff_i && !blocked) begin
      acc_o      = 1'b1;
      kind_o     = KIND_IRQ;
      take_irq_o = 1'b1;
    end
    if (acc_o) begin
      redir_o    = 1'b1;
      redir_pc_o = vec_i;
      sr_wr_o    = 1'b1;
      sr_new_o   = cur_sr_i | BL_MASK;
    end
  end

  // R9: at most one action per cycle
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({mrst_o, ubrk_o, acc_o, rte_take}));
  // R6: no ordinary interrupt is taken while blocked
  p_irq_held_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    blocked |-> !take_irq_o);
  // R5: user break never redirects
  p_ubrk_quiet_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ubrk_o |-> !redir_o && !sr_wr_o);
endmodule

// File: rtl/exc_save_regs.sv
module exc_save_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic            flush_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] sr_i,
  output logic [XLEN-1:0] spc_o,
  output logic [XLEN-1:0] ssr_o
);
  logic [XLEN-1:0] spc_q, ssr_q, spc_d, ssr_d;
  logic            en;

  assign en = acc_i | flush_i;

  always_comb begin
    spc_d = flush_i ? '0 : pc_i;
    ssr_d = flush_i ? '0 : sr_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_q <= '0;
      ssr_q <= '0;
    end else if (en) begin
      spc_q <= spc_d;
      ssr_q <= ssr_d;
    end
  end

  assign spc_o = spc_q;
  assign ssr_o = ssr_q;

  // R2: saved pair captures the accepting cycle's PC and SR
  p_save_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_i && !flush_i |=> spc_q == $past(pc_i) && ssr_q == $past(sr_i));
  // R4: reset request zeroes the saved pair
  p_flush_zero_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_i |=> spc_q == '0 && ssr_q == '0);
  // R2: saved pair holds when idle
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> $stable(spc_q) && $stable(ssr_q));
endmodule

// File: rtl/exc_accept_ctrl.sv
module exc_accept_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int unsigned       XLEN      = 32,
  parameter int unsigned       TYPE_W    = 6,
  parameter int unsigned       BL_BIT    = 28,
  parameter logic [TYPE_W-1:0] UBRK_CODE = '1,
  parameter logic [XLEN-1:0]   RST_PC    = 32'hA000_0000,
  parameter logic [XLEN-1:0]   RST_SR    = 32'h7000_00F0,
  parameter int unsigned       SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req_i,
  input  logic [TYPE_W-1:0] exc_type_i,
  input  logic              irq_req_i,
  input  logic              nmi_req_i,
  input  logic              nmi_blk_take_i,
  input  logic              rte_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [XLEN-1:0]   cur_sr_i,
  input  logic [XLEN-1:0]   vec_i,
  output logic              redir_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic              sr_wr_o,
  output logic [XLEN-1:0]   sr_new_o,
  output logic [1:0]        acc_kind_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic              mrst_o,
  output logic              ubrk_o
);
  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  logic [NUM_SRC-1:0] src_req, src_take, src_eff;
  logic               acc, mrst, take_nmi, take_irq;
  acc_kind_e          kind;

  assign src_req[SRC_NMI]  = nmi_req_i;
  assign src_req[SRC_IRQ]  = irq_req_i;
  assign src_take[SRC_NMI] = take_nmi;
  assign src_take[SRC_IRQ] = take_irq;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    exc_pend_flag u_flag (
      .clk     (clk),
      .rst_ni  (rst_int_n),
      .req_i   (src_req[g]),
      .take_i  (src_take[g]),
      .flush_i (mrst),
      .eff_o   (src_eff[g])
    );
  end

  exc_arbiter #(
    .XLEN(XLEN), .TYPE_W(TYPE_W), .BL_BIT(BL_BIT),
    .UBRK_CODE(UBRK_CODE), .RST_PC(RST_PC), .RST_SR(RST_SR)
  ) u_arb (
    .clk            (clk),
    .rst_ni         (rst_int_n),
    .exc_req_i      (exc_req_i),
    .exc_type_i     (exc_type_i),
    .nmi_eff_i      (src_eff[SRC_NMI]),
    .irq_eff_i      (src_eff[SRC_IRQ]),
    .nmi_blk_take_i (nmi_blk_take_i),
    .rte_i          (rte_i),
    .cur_sr_i       (cur_sr_i),
    .vec_i          (vec_i),
    .spc_i          (spc_o),
    .ssr_i          (ssr_o),
    .acc_o          (acc),
    .kind_o         (kind),
    .mrst_o         (mrst),
    .ubrk_o         (ubrk_o),
    .take_nmi_o     (take_nmi),
    .take_irq_o     (take_irq),
    .redir_o        (redir_o),
    .redir_pc_o     (redir_pc_o),
    .sr_wr_o        (sr_wr_o),
    .sr_new_o       (sr_new_o)
  );

  exc_save_regs #(.XLEN(XLEN)) u_save (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .acc_i   (acc),
    .flush_i (mrst),
    .pc_i    (cur_pc_i),
    .sr_i    (cur_sr_i),
    .spc_o   (spc_o),
    .ssr_o   (ssr_o)
  );

  assign acc_kind_o = kind;
  assign mrst_o     = mrst;

  // R3: reset path always targets the fixed address
  p_mrst_target_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    mrst_o |-> redir_o && redir_pc_o == RST_PC && sr_new_o == RST_SR);
  // R8: return reloads from the saved pair
  p_rte_restore_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rte_i && !exc_req_i |-> redir_pc_o == spc_o && sr_new_o == ssr_o);
endmodule

// File: tb/exc_accept_ctrl_tb.sv
module exc_accept_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        exc_req, irq_req, nmi_req, nmi_pol, rte;
  logic [5:0]  exc_type;
  logic [31:0] pc, sr, vec;
  logic        redir, sr_wr, mrst, ubrk;
  logic [31:0] redir_pc, sr_new, spc, ssr;
  logic [1:0]  kind;

  exc_accept_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_type_i(exc_type),
    .irq_req_i(irq_req), .nmi_req_i(nmi_req), .nmi_blk_take_i(nmi_pol),
    .rte_i(rte), .cur_pc_i(pc), .cur_sr_i(sr), .vec_i(vec),
    .redir_o(redir), .redir_pc_o(redir_pc), .sr_wr_o(sr_wr), .sr_new_o(sr_new),
    .acc_kind_o(kind), .spc_o(spc), .ssr_o(ssr), .mrst_o(mrst), .ubrk_o(ubrk)
  );

  localparam logic [31:0] BLK = 32'h1000_0000;
  int total = 0, bad = 0;

  // reference model state
  bit          m_nmi_p, m_irq_p;
  logic [31:0] m_spc, m_ssr;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit e, logic [5:0] t, bit i, bit n, bit pol,
                      bit r, logic [31:0] p, logic [31:0] s, logic [31:0] v);
    bit blk, ne, ie, e_redir, e_srwr, e_mrst, e_ubrk, acc, tn, ti;
    logic [31:0] e_pc, e_sr;
    int e_kind;
    @(negedge clk);
    exc_req = e; exc_type = t; irq_req = i; nmi_req = n; nmi_pol = pol;
    rte = r; pc = p; sr = s; vec = v;
    #1;
    blk = s[28]; ne = m_nmi_p || n; ie = m_irq_p || i;
    e_redir = 0; e_srwr = 0; e_mrst = 0; e_ubrk = 0; acc = 0; tn = 0; ti = 0;
    e_pc = 0; e_sr = 0; e_kind = 0;
    if (e) begin
      if (!blk) begin acc = 1; e_kind = 1; end
      else if (t == 6'h3F) e_ubrk = 1;
      else begin
        e_mrst = 1; e_redir = 1; e_srwr = 1;
        e_pc = 32'hA000_0000; e_sr = 32'h7000_00F0;
      end
    end else if (r) begin
      e_redir = 1; e_srwr = 1; e_pc = m_spc; e_sr = m_ssr;
    end else if (ne && (!blk || pol)) begin
      acc = 1; e_kind = 2; tn = 1;
    end else if (ie && !blk) begin
      acc = 1; e_kind = 3; ti = 1;
    end
    if (acc) begin e_redir = 1; e_srwr = 1; e_pc = v; e_sr = s | BLK; end
    check(req, {31'b0, redir}, {31'b0, e_redir}, "redir");
    check(req, redir_pc, e_pc, "redir_pc");
    check(req, {31'b0, sr_wr}, {31'b0, e_srwr}, "sr_wr");
    check(req, sr_new, e_sr, "sr_new");
    check(req, {30'b0, kind}, 32'(e_kind), "kind");
    check(req, {31'b0, mrst}, {31'b0, e_mrst}, "mrst");
    check(req, {31'b0, ubrk}, {31'b0, e_ubrk}, "ubrk");
    check(req, spc, m_spc, "spc");
    check(req, ssr, m_ssr, "ssr");
    @(posedge clk);
    if (e_mrst) begin
      m_nmi_p = 0; m_irq_p = 0; m_spc = 0; m_ssr = 0;
    end else begin
      m_nmi_p = ne && !tn;
      m_irq_p = ie && !ti;
      if (acc) begin m_spc = p; m_ssr = s; end
    end
  endtask

  task automatic idle(string req, logic [31:0] s);
    step(req, 0, 0, 0, 0, 0, 0, 32'h0, s, 32'h0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_nmi_p = 0; m_irq_p = 0; m_spc = 0; m_ssr = 0;
    exc_req = 0; exc_type = 0; irq_req = 0; nmi_req = 0; nmi_pol = 0;
    rte = 0; pc = 0; sr = 0; vec = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    idle("R11", 0);
    // R1 / R2: unblocked exception then observe saved pair
    step("R1", 1, 6'h05, 0, 0, 0, 0, 32'h0000_1000, 32'h0000_00F0, 32'h8000_0100);
    idle("R2", BLK);
    // R8: return
    step("R8", 0, 0, 0, 0, 0, 1, 32'h8000_0104, BLK, 0);
    // R6: interrupt parked while blocked, taken when unblocked
    step("R6", 0, 0, 1, 0, 0, 0, 32'h2000, BLK, 32'h8000_0600);
    idle("R6", BLK);
    idle("R6", BLK);
    step("R6", 0, 0, 0, 0, 0, 0, 32'h2004, 32'h0000_0001, 32'h8000_0600);
    idle("R10", 0);
    // R7: NMI parked with policy 0, taken when policy set
    step("R7", 0, 0, 0, 1, 0, 0, 32'h3000, BLK, 32'h8000_01C0);
    idle("R7", BLK);
    step("R7", 0, 0, 0, 0, 1, 0, 32'h3008, BLK, 32'h8000_01C0);
    step("R10", 0, 0, 0, 0, 1, 0, 32'h300C, 0, 32'h8000_01C0);
    // R7: immediate take while blocked under policy 1
    step("R7", 0, 0, 0, 1, 1, 0, 32'h3100, BLK | 32'h3, 32'h8000_01C0);
    // R7: parked NMI released by clearing the block bit
    step("R7", 0, 0, 0, 1, 0, 0, 32'h3200, BLK, 32'h8000_01C0);
    step("R7", 0, 0, 0, 0, 0, 0, 32'h3204, 32'h4, 32'h8000_01C0);
    // R9: exception beats interrupt, interrupt then taken
    step("R9", 1, 6'h02, 1, 0, 0, 0, 32'h4000, 0, 32'h8000_0100);
    step("R9", 0, 0, 0, 0, 0, 0, 32'h4100, 0, 32'h8000_0600);
    // R9: return beats NMI, NMI then taken
    step("R9", 0, 0, 0, 1, 0, 1, 32'h4200, BLK, 32'h8000_01C0);
    step("R9", 0, 0, 0, 0, 0, 0, 32'h4300, 0, 32'h8000_01C0);
    // R9: exception beats NMI and interrupt together
    step("R9", 1, 6'h07, 1, 1, 0, 0, 32'h4400, 0, 32'h8000_0100);
    step("R9", 0, 0, 0, 0, 0, 0, 32'h4500, BLK, 32'h8000_01C0);
    // R5: user break while blocked
    step("R5", 1, 6'h3F, 0, 0, 0, 0, 32'h5000, BLK, 32'h8000_0100);
    idle("R5", BLK);
    // R1: user-break code unblocked is accepted as exception
    step("R1", 1, 6'h3F, 0, 0, 0, 0, 32'h5100, 32'h2, 32'h8000_0100);
    // R3 / R4: blocked exception with interrupt parked and one arriving
    step("R3", 0, 0, 1, 0, 0, 0, 32'h6000, BLK, 0);
    step("R3", 1, 6'h01, 0, 1, 0, 0, 32'h6004, BLK, 32'h8000_0100);
    idle("R4", 0);
    idle("R4", 0);
    // R8: return after reset path uses zeroed pair
    step("R8", 0, 0, 0, 0, 0, 1, 32'h7000, BLK, 0);
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule